// File: doc/BRIEF.md
# DRAM 2:1 Compressed Test Mode Controller

This block sits on the device side of a multiplexed-address memory. The memory has eight external data bits, and its core is sixteen bits wide. The block watches the row strobe, the column strobe and the write strobe to classify each row cycle, and it keeps a test-mode flag. The flag is set by a qualified write-and-column-before-row cycle. It is cleared by any refresh cycle that is not such a cycle.

In normal operation the block decodes column accesses. A write goes to one half of the core, chosen by the top row address bit. A read returns that half on the external data pins. In test mode that address bit is ignored:
- A write drives each external bit into the same position of both halves in one core access.
- A read returns, for each bit position, 1 when the two internal copies agree and 0 when they differ.

All strobes are active low. They are sampled by a fast internal clock, and every timing window is counted in samples of that clock. The core is outside the block. The core is reached through plain row, column, lane-enable, write and read pins, and it answers a read one clock after the read pulse. There is no valid/ready handshake and no back-pressure on either side. The strobe cycle is the transfer protocol: a column access is accepted on every column-strobe falling edge inside an access cycle, and it can never be stalled.

Top module: `dram_cmptest`

## Requirements
- R1: After reset, `test_mode` is 0, `dq_oe` is 0 and neither core enable is asserted.
- R2: Test mode is entered when all of the following hold at the row strobe falling edge: the column strobe is low, the write strobe is low, and address bits 9..0 are all 1. Address bit 10 is ignored for entry.
- R3: An entry attempt with any of address bits 9..0 at 0 leaves `test_mode` at 0.
- R4: Entry also requires three timing conditions, counted in samples. The write strobe is low for at least 3 samples before the falling-edge sample. The write strobe stays low for 3 samples after it. The column strobe stays low for 8 samples after it. If any of these fails, entry is refused.
- R5: In test mode, a row cycle that starts with the column strobe low and the write strobe high clears `test_mode`.
- R6: In test mode, a row cycle that starts with the column strobe high and ends with no column strobe fall clears `test_mode`.
- R7: In test mode, a hidden refresh clears `test_mode`. A hidden refresh keeps the column strobe low from a read, through the row strobe rising, into a new row strobe fall.
- R8: In test mode, a cycle with both column and write strobes low at the row fall keeps `test_mode` at 1, whatever the address.
- R9: A test-mode write enables both lanes (`arr_lane_en` = 2'b11) with `arr_wdata` = {dq_in, dq_in}. The data reads back identically from either half afterwards.
- R10: A test-mode read sets each `dq_out[i]` to the XNOR of core bits i and i+8. Row address bit 10 has no effect on this result.
- R11: A normal-mode write enables only lane 0 (bits 7..0) when row bit 10 is 0, and only lane 1 (bits 15..8) when row bit 10 is 1.
- R12: A normal-mode read returns core bits 7..0 when row bit 10 is 0 and bits 15..8 when it is 1.
- R13: `dq_oe` rises once the read data is captured. It falls after the column strobe rises, and it stays low during writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | External write data |
| arr_rdata | input | 2*DQ_W | Core read data, valid one clock after `arr_rd_en` |
| test_mode | output | 1 | Compressed test mode active |
| arr_row | output | ROW_W-1 | Core row (row address without its top bit) |
| arr_col | output | COL_W | Core column |
| arr_wr_en | output | 1 | Core write pulse |
| arr_lane_en | output | 2 | Half enables: bit 0 for bits 7..0, bit 1 for bits 15..8 |
| arr_wdata | output | 2*DQ_W | Core write data |
| arr_rd_en | output | 1 | Core read pulse |
| dq_out | output | DQ_W | External read data or compare result |
| dq_oe | output | 1 | External data output enable |

## Verification
The assertions take two things for granted:
- The row strobe stays low for at least the 8-sample hold window of a refresh-type cycle.
- No column strobe fall comes in the same sample as a row strobe rise.

The stimulus keeps within both: every refresh-type cycle holds the row strobe low for 14 samples, and every column access ends several samples before the row strobe is released. The stimulus also drives the address and data together with their strobe edges, at the falling clock edge. This matches the single sampling stage the block assumes for those inputs.

// File: rtl/tmc_pkg.sv
`timescale 1ns/1ps
package tmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_ACCESS   = 2'd1,
    ST_CBR_HOLD = 2'd2,
    ST_CBR_WAIT = 2'd3
  } cyc_state_t;

  localparam int unsigned LANES = 2;
endpackage

// File: rtl/tmc_sampler.sv
`timescale 1ns/1ps
module tmc_sampler #(
  parameter int ADDR_W = 11,
  parameter int DQ_W   = 8,
  parameter int WE_SU  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic              s_ras,
  output logic              s_cas,
  output logic              s_we,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DQ_W-1:0]   s_dq,
  output logic              ras_fall,
  output logic              cas_fall,
  output logic              cas_rise,
  output logic [$clog2(WE_SU+2):0] we_run
);
  localparam int RUN_W = $clog2(WE_SU+2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(WE_SU + 1);

  logic p_ras, p_cas;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ras  <= 1'b1;
      s_cas  <= 1'b1;
      s_we   <= 1'b1;
      p_ras  <= 1'b1;
      p_cas  <= 1'b1;
      s_addr <= '0;
      s_dq   <= '0;
      we_run <= '0;
    end else begin
      s_ras  <= ras_n;
      s_cas  <= cas_n;
      s_we   <= we_n;
      p_ras  <= s_ras;
      p_cas  <= s_cas;
      s_addr <= addr;
      s_dq   <= dq_in;
      if (we_n)
        we_run <= '0;
      else if (we_run != RUN_MAX)
        we_run <= we_run + 1'b1;
    end
  end

  assign ras_fall = p_ras & ~s_ras;
  assign cas_fall = p_cas & ~s_cas;
  assign cas_rise = ~p_cas & s_cas;

  p_run_zero_when_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_we |-> (we_run == '0));
endmodule

// File: rtl/tmc_cycle_fsm.sv
`timescale 1ns/1ps
module tmc_cycle_fsm
  import tmc_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int ROW_W      = 11,
  parameter int ENTRY_BITS = 10,
  parameter int WE_SU      = 3,
  parameter int WE_HD      = 3,
  parameter int CAS_HD     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_ras,
  input  logic              s_cas,
  input  logic              s_we,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic              ras_fall,
  input  logic              cas_fall,
  input  logic [$clog2(WE_SU+2):0] we_run,
  output logic              test_mode,
  output logic [ROW_W-1:0]  row_q,
  output logic              col_strobe,
  output logic              col_is_write
);
  localparam int HOLD_MAX = (CAS_HD > WE_HD) ? CAS_HD : WE_HD;
  localparam int HC_W     = $clog2(HOLD_MAX + 1);
  localparam int RUN_W    = $clog2(WE_SU+2) + 1;

  cyc_state_t      state_q;
  logic [HC_W-1:0] hcnt_q, cnt_n;
  logic tm_q, cas_seen_q;
  logic pat_ok_q, su_ok_q, we_at_fall_q;
  logic we_fail_q, cas_fail_q, we_fail_n, cas_fail_n;
  logic window_end, entry_ok;

  always_comb begin
    cnt_n      = hcnt_q + 1'b1;
    we_fail_n  = we_fail_q  | ((cnt_n <= HC_W'(WE_HD))  & s_we);
    cas_fail_n = cas_fail_q | ((cnt_n <= HC_W'(CAS_HD)) & s_cas);
    window_end = (state_q == ST_CBR_HOLD) && (cnt_n == HC_W'(HOLD_MAX));
    entry_ok   = we_at_fall_q & pat_ok_q & su_ok_q & ~we_fail_n & ~cas_fail_n;
  end

  assign col_strobe   = (state_q == ST_ACCESS) & cas_fall & ~s_ras;
  assign col_is_write = ~s_we;
  assign test_mode    = tm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      hcnt_q       <= '0;
      tm_q         <= 1'b0;
      cas_seen_q   <= 1'b0;
      pat_ok_q     <= 1'b0;
      su_ok_q      <= 1'b0;
      we_at_fall_q <= 1'b0;
      we_fail_q    <= 1'b0;
      cas_fail_q   <= 1'b0;
      row_q        <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (ras_fall) begin
          row_q <= s_addr[ROW_W-1:0];
          if (!s_cas) begin
            state_q      <= ST_CBR_HOLD;
            hcnt_q       <= '0;
            pat_ok_q     <= &s_addr[ENTRY_BITS-1:0];
            we_at_fall_q <= ~s_we;
            su_ok_q      <= ~s_we & (we_run >= RUN_W'(WE_SU + 1));
            we_fail_q    <= 1'b0;
            cas_fail_q   <= 1'b0;
          end else begin
            state_q    <= ST_ACCESS;
            cas_seen_q <= 1'b0;
          end
        end
        ST_ACCESS: begin
          if (col_strobe) cas_seen_q <= 1'b1;
          if (s_ras) begin
            state_q <= ST_IDLE;
            if (!cas_seen_q) tm_q <= 1'b0;
          end
        end
        ST_CBR_HOLD: begin
          hcnt_q     <= cnt_n;
          we_fail_q  <= we_fail_n;
          cas_fail_q <= cas_fail_n;
          if (window_end) begin
            tm_q    <= tm_q ? we_at_fall_q : entry_ok;
            state_q <= ST_CBR_WAIT;
          end
        end
        default: if (s_ras) state_q <= ST_IDLE;
      endcase
    end
  end

  p_tm_flip_in_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_q != $past(tm_q)) |-> ($past(state_q) == ST_CBR_HOLD || $past(state_q) == ST_ACCESS));

  p_entry_needs_pattern_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tm_q) |-> (pat_ok_q && su_ok_q && we_at_fall_q));

  p_rasonly_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACCESS && s_ras && !cas_seen_q) |=> !tm_q);

  p_access_keeps_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACCESS && $past(state_q) == ST_ACCESS) |-> $stable(tm_q));
endmodule

// File: rtl/tmc_datapath.sv
`timescale 1ns/1ps
module tmc_datapath
  import tmc_pkg::*;
#(
  parameter int DQ_W  = 8,
  parameter int COL_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                test_mode,
  input  logic                half_sel,
  input  logic                col_strobe,
  input  logic                col_is_write,
  input  logic [COL_W-1:0]    col_addr,
  input  logic [DQ_W-1:0]     s_dq,
  input  logic                cas_rise,
  input  logic [2*DQ_W-1:0]   arr_rdata,
  output logic [COL_W-1:0]    arr_col,
  output logic                arr_wr_en,
  output logic [LANES-1:0]    arr_lane_en,
  output logic [2*DQ_W-1:0]   arr_wdata,
  output logic                arr_rd_en,
  output logic [DQ_W-1:0]     dq_out,
  output logic                dq_oe
);
  logic [DQ_W-1:0] cmp_vec, sel_vec;
  logic rd_cap_q, rd_tm_q, rd_half_q;

  for (genvar i = 0; i < DQ_W; i++) begin : g_cmp
    assign cmp_vec[i] = ~(arr_rdata[i] ^ arr_rdata[i+DQ_W]);
  end
  assign sel_vec = rd_half_q ? arr_rdata[2*DQ_W-1:DQ_W] : arr_rdata[DQ_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_col     <= '0;
      arr_wr_en   <= 1'b0;
      arr_rd_en   <= 1'b0;
      arr_lane_en <= '0;
      arr_wdata   <= '0;
      rd_cap_q    <= 1'b0;
      rd_tm_q     <= 1'b0;
      rd_half_q   <= 1'b0;
      dq_out      <= '0;
      dq_oe       <= 1'b0;
    end else begin
      arr_wr_en <= col_strobe & col_is_write;
      arr_rd_en <= col_strobe & ~col_is_write;
      rd_cap_q  <= arr_rd_en;
      if (col_strobe) begin
        arr_col     <= col_addr;
        arr_wdata   <= {s_dq, s_dq};
        arr_lane_en <= test_mode ? 2'b11 : (half_sel ? 2'b10 : 2'b01);
        rd_tm_q     <= test_mode;
        rd_half_q   <= half_sel;
      end
      if (rd_cap_q) begin
        dq_out <= rd_tm_q ? cmp_vec : sel_vec;
        dq_oe  <= 1'b1;
      end else if (cas_rise || arr_wr_en) begin
        dq_oe  <= 1'b0;
      end
    end
  end

  p_tm_both_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_en && test_mode) |-> (arr_lane_en == 2'b11 &&
      arr_wdata[2*DQ_W-1:DQ_W] == arr_wdata[DQ_W-1:0]));

  p_norm_one_lane_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_en && !test_mode) |-> ($countones(arr_lane_en) == 1));

  p_oe_off_after_cas_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_rise && !rd_cap_q) |=> !dq_oe);

  p_wr_rd_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(arr_wr_en && arr_rd_en));
endmodule

// File: rtl/dram_cmptest.sv
`timescale 1ns/1ps
module dram_cmptest
  import tmc_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int ROW_W      = 11,
  parameter int COL_W      = 10,
  parameter int DQ_W       = 8,
  parameter int ENTRY_BITS = 10,
  parameter int WE_SU_CYC  = 3,
  parameter int WE_HD_CYC  = 3,
  parameter int CAS_HD_CYC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DQ_W-1:0]     dq_in,
  input  logic [2*DQ_W-1:0]   arr_rdata,
  output logic                test_mode,
  output logic [ROW_W-2:0]    arr_row,
  output logic [COL_W-1:0]    arr_col,
  output logic                arr_wr_en,
  output logic [LANES-1:0]    arr_lane_en,
  output logic [2*DQ_W-1:0]   arr_wdata,
  output logic                arr_rd_en,
  output logic [DQ_W-1:0]     dq_out,
  output logic                dq_oe
);
  localparam int RUN_W = $clog2(WE_SU_CYC+2) + 1;

  logic              s_ras, s_cas, s_we;
  logic [ADDR_W-1:0] s_addr;
  logic [DQ_W-1:0]   s_dq;
  logic              ras_fall, cas_fall, cas_rise;
  logic [RUN_W-1:0]  we_run;
  logic [ROW_W-1:0]  row_q;
  logic              col_strobe, col_is_write;

  tmc_sampler #(.ADDR_W(ADDR_W), .DQ_W(DQ_W), .WE_SU(WE_SU_CYC)) u_smp (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .s_ras(s_ras), .s_cas(s_cas), .s_we(s_we),
    .s_addr(s_addr), .s_dq(s_dq), .ras_fall(ras_fall), .cas_fall(cas_fall),
    .cas_rise(cas_rise), .we_run(we_run));

  tmc_cycle_fsm #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .ENTRY_BITS(ENTRY_BITS),
    .WE_SU(WE_SU_CYC), .WE_HD(WE_HD_CYC), .CAS_HD(CAS_HD_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .s_ras(s_ras), .s_cas(s_cas), .s_we(s_we),
    .s_addr(s_addr), .ras_fall(ras_fall), .cas_fall(cas_fall), .we_run(we_run),
    .test_mode(test_mode), .row_q(row_q), .col_strobe(col_strobe),
    .col_is_write(col_is_write));

  assign arr_row = row_q[ROW_W-2:0];

  tmc_datapath #(.DQ_W(DQ_W), .COL_W(COL_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .half_sel(row_q[ROW_W-1]),
    .col_strobe(col_strobe), .col_is_write(col_is_write),
    .col_addr(s_addr[COL_W-1:0]), .s_dq(s_dq), .cas_rise(cas_rise),
    .arr_rdata(arr_rdata), .arr_col(arr_col), .arr_wr_en(arr_wr_en),
    .arr_lane_en(arr_lane_en), .arr_wdata(arr_wdata), .arr_rd_en(arr_rd_en),
    .dq_out(dq_out), .dq_oe(dq_oe));

  p_mode_steady_ras_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(s_ras) && s_ras && $past(s_ras, 2)) |-> $stable(test_mode));
endmodule

// File: tb/dram_cmptest_bench.sv
`timescale 1ns/1ps
module dram_cmptest_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [10:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [15:0] arr_rdata;
  logic        test_mode, arr_wr_en, arr_rd_en, dq_oe;
  logic [9:0]  arr_row, arr_col;
  logic [1:0]  arr_lane_en;
  logic [15:0] arr_wdata;
  logic [7:0]  dq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_cmptest u_dram_cmptest (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .arr_rdata(arr_rdata), .test_mode(test_mode),
    .arr_row(arr_row), .arr_col(arr_col), .arr_wr_en(arr_wr_en),
    .arr_lane_en(arr_lane_en), .arr_wdata(arr_wdata), .arr_rd_en(arr_rd_en),
    .dq_out(dq_out), .dq_oe(dq_oe));

  // behavioural core: 16-bit words keyed by {row, col}
  logic [15:0] mem [int];
  int key;
  logic [15:0] cur;
  assign key = int'({arr_row, arr_col});
  always @(posedge clk) begin
    if (arr_wr_en) begin
      cur = mem.exists(key) ? mem[key] : 16'h0;
      if (arr_lane_en[0]) cur[7:0]  = arr_wdata[7:0];
      if (arr_lane_en[1]) cur[15:8] = arr_wdata[15:8];
      mem[key] = cur;
    end
    if (arr_rd_en) arr_rdata <= mem.exists(key) ? mem[key] : 16'h0;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc_write(input logic [10:0] row, input logic [9:0] col, input logic [7:0] d);
    addr = row; ras_n = 0; idle(4);
    addr = {1'b0, col}; dq_in = d; we_n = 0; idle(2);
    cas_n = 0; idle(4);
    chk("R13 oe low in write", {15'b0, dq_oe}, 16'h0);
    cas_n = 1; we_n = 1; idle(2);
    ras_n = 1; idle(4);
  endtask

  // returns data; keep_cas leaves CAS low for a hidden refresh
  task automatic acc_read(input logic [10:0] row, input logic [9:0] col,
                          input bit keep_cas, output logic [7:0] d);
    addr = row; ras_n = 0; idle(4);
    addr = {1'b0, col}; idle(2);
    cas_n = 0; idle(6);
    d = dq_out;
    chk("R13 oe high on read", {15'b0, dq_oe}, 16'h1);
    if (!keep_cas) begin
      cas_n = 1; idle(3);
      chk("R13 oe low after cas", {15'b0, dq_oe}, 16'h0);
      ras_n = 1; idle(4);
    end
  endtask

  task automatic wcbr(input logic [10:0] a, input int su, input int whd, input int chd);
    cas_n = 0; we_n = 0; addr = a; idle(su);
    ras_n = 0; idle(whd);
    we_n = 1; idle(chd - whd);
    cas_n = 1; idle(14 - chd);
    ras_n = 1; idle(6);
  endtask

  task automatic t_reset;
    chk("R1 test_mode", {15'b0, test_mode}, 16'h0);
    chk("R1 dq_oe", {15'b0, dq_oe}, 16'h0);
    chk("R1 enables", {14'b0, arr_wr_en, arr_rd_en}, 16'h0);
  endtask

  task automatic t_normal;
    logic [7:0] d;
    acc_write(11'h005, 10'd5, 8'h3C);
    acc_write(11'h405, 10'd5, 8'h35);
    acc_read(11'h005, 10'd5, 0, d); chk("R11 R12 lane0 read", {8'h0, d}, 16'h003C);
    acc_read(11'h405, 10'd5, 0, d); chk("R11 R12 lane1 read", {8'h0, d}, 16'h0035);
  endtask

  task automatic t_refused;
    wcbr(11'h3FE, 4, 4, 9); chk("R3 bad pattern refused", {15'b0, test_mode}, 16'h0);
    wcbr(11'h3FF, 1, 4, 9); chk("R4 WE setup short refused", {15'b0, test_mode}, 16'h0);
    wcbr(11'h3FF, 4, 2, 9); chk("R4 WE hold short refused", {15'b0, test_mode}, 16'h0);
    wcbr(11'h3FF, 4, 4, 5); chk("R4 CAS hold short refused", {15'b0, test_mode}, 16'h0);
  endtask

  task automatic t_enter_and_compress;
    logic [7:0] d;
    wcbr(11'h7FF, 4, 4, 9); chk("R2 entry with A10 set", {15'b0, test_mode}, 16'h1);
    acc_read(11'h005, 10'd5, 0, d); chk("R10 compare mismatch", {8'h0, d}, 16'h00F6);
    acc_read(11'h405, 10'd5, 0, d); chk("R10 A10 ignored", {8'h0, d}, 16'h00F6);
    acc_write(11'h405, 10'd6, 8'hA5);
    acc_read(11'h005, 10'd6, 0, d); chk("R9 R10 compare match", {8'h0, d}, 16'h00FF);
    wcbr(11'h000, 4, 4, 9); chk("R8 WCBR keeps mode", {15'b0, test_mode}, 16'h1);
  endtask

  task automatic t_exit_cbr;
    logic [7:0] d;
    cas_n = 0; idle(3); ras_n = 0; idle(14); ras_n = 1; cas_n = 1; idle(6);
    chk("R5 CBR exit", {15'b0, test_mode}, 16'h0);
    acc_read(11'h005, 10'd6, 0, d); chk("R9 lane0 copy", {8'h0, d}, 16'h00A5);
    acc_read(11'h405, 10'd6, 0, d); chk("R9 lane1 copy", {8'h0, d}, 16'h00A5);
  endtask

  task automatic t_exit_rasonly;
    wcbr(11'h3FF, 4, 4, 9); chk("R2 re-entry", {15'b0, test_mode}, 16'h1);
    addr = 11'h010; ras_n = 0; idle(10); ras_n = 1; idle(6);
    chk("R6 RAS-only exit", {15'b0, test_mode}, 16'h0);
  endtask

  task automatic t_exit_hidden;
    logic [7:0] d;
    wcbr(11'h3FF, 4, 4, 9); chk("R2 re-entry 2", {15'b0, test_mode}, 16'h1);
    acc_read(11'h005, 10'd5, 1, d); chk("R10 read before hidden", {8'h0, d}, 16'h00F6);
    chk("R7 still in mode", {15'b0, test_mode}, 16'h1);
    ras_n = 1; idle(4); ras_n = 0; idle(14); ras_n = 1; idle(2); cas_n = 1; idle(6);
    chk("R7 hidden refresh exit", {15'b0, test_mode}, 16'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    t_reset;
    rst_n = 1; idle(3);
    t_normal;
    t_refused;
    t_enter_and_compress;
    t_exit_cbr;
    t_exit_rasonly;
    t_exit_hidden;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule